// File: doc/BRIEF.md
# Cascaded Device Select and Output Ownership

This block sits in one device of a chain of up to eight cascaded multi-queue devices that share address buses and a common data output bus. It takes the queue address on the write port and on the read port, splits it into a device field and a local queue field, and decides whether this device is the one being addressed. When it is, the block reports the local queue index that the rest of the device should use.

The same block decides whether this device may drive the shared data output bus. After a master reset, the device strapped as master owns the bus. Every slave keeps its outputs off. Ownership then moves to whichever device the read port selects. A null-queue request on the read port leaves the current owner in place and reads no queue. The final drive enable combines ownership with an active-low output enable that acts without a clock.

The device identity and the master strap are sampled while master reset is asserted. Master reset is a synchronous, active-high input that must span at least one edge of each port clock. All port decisions are registered on the clock of their port. The drive enable is the only combinational output.

Top module: `mq_dev_select`

## Requirements
- R1: While `mrst` is high at a clock edge, that port's hit flag and queue index are cleared to 0, and `bus_owner` becomes the value of `strap_master`.
- R2: `strap_id` and `strap_master` are captured only at edges where `mrst` is high. Changing them while `mrst` is low has no effect on address matching or on ownership until the next reset.
- R3: At a `wclk` edge with `wr_en` high, the device field (address bits [5:3]) is compared with the captured ID. On a match, `wr_hit` becomes 1 and `wr_queue` takes bits [2:0]. On a mismatch, `wr_hit` becomes 0 and `wr_queue` keeps its value.
- R4: At a `wclk` edge with `wr_en` low, `wr_hit` and `wr_queue` keep their values.
- R5: At an `rclk` edge with `rd_en` high and `rd_null` low, `rd_hit` and `rd_queue` follow the same match rule as R3, using `rd_addr`. With `rd_en` low they hold.
- R6: At an `rclk` edge with `rd_en` and `rd_null` both high, `rd_hit` becomes 0, `rd_queue` keeps its value, and `bus_owner` is unchanged, whatever the address.
- R7: At an `rclk` edge with `rd_en` high and `rd_null` low, `bus_owner` becomes 1 if the device field matches the captured ID and 0 otherwise. With `rd_en` low it holds.
- R8: `dout_en` is 1 exactly when `bus_owner` is 1 and `oe_n` is 0. It follows `oe_n` without waiting for a clock edge.
- R9: After reset, a slave keeps `dout_en` at 0 even with `oe_n` low, until a read selection addresses it.
- R10: In a chain of devices with distinct IDs and exactly one master that share the buses, at most one device has `dout_en` high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write port clock |
| rclk | input | 1 | Read port clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| strap_id | input | 3 | Device identity strap, sampled during reset |
| strap_master | input | 1 | Master role strap, sampled during reset |
| wr_en | input | 1 | Write address valid |
| wr_addr | input | 6 | Write queue address: device in [5:3], queue in [2:0] |
| rd_en | input | 1 | Read address valid |
| rd_null | input | 1 | Read selection targets the null queue |
| rd_addr | input | 6 | Read queue address: device in [5:3], queue in [2:0] |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wr_hit | output | 1 | This device is selected on the write port |
| wr_queue | output | 3 | Local queue index on the write port |
| rd_hit | output | 1 | This device is selected on the read port for a real queue |
| rd_queue | output | 3 | Local queue index on the read port |
| bus_owner | output | 1 | This device owns the shared output bus |
| dout_en | output | 1 | Drive enable for the shared data output bus |

## Verification
The bench builds the block with its default 3-bit device and 3-bit queue fields and places four copies of it on shared buses. The copies have IDs 0, 3, 5 and 7, and the master is the device with ID 3, so the master is not the one at ID 0. Because the devices share buses, ownership handover, master-first behaviour after reset and the absence of bus contention become observable at the ports in every cycle. A second reset that moves the master role and rewrites a strap shows that identities are taken only while reset is held.

// File: rtl/mq_sel_pkg.sv
package mq_sel_pkg;

    // Field widths of a queue address shared across the chain
    localparam int DEV_W  = 3;
    localparam int QUE_W  = 3;
    localparam int ADDR_W = DEV_W + QUE_W;

    typedef logic [DEV_W-1:0] dev_id_t;
    typedef logic [QUE_W-1:0] que_idx_t;

    // Device field is the upper part of the address; the cascade decodes it
    typedef struct packed {
        dev_id_t  dev;
        que_idx_t que;
    } qaddr_t;

    // Registered selection state of one port
    typedef struct packed {
        logic     hit;
        que_idx_t que;
    } qsel_t;

    // What an address cycle means for this device
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_LOCAL  = 2'd1,
        ACT_REMOTE = 2'd2,
        ACT_NULL   = 2'd3
    } sel_act_e;

    function automatic sel_act_e classify(input logic    en,
                                          input logic    null_req,
                                          input qaddr_t  a,
                                          input dev_id_t id);
        sel_act_e r;
        if (!en)
            r = ACT_IDLE;
        else if (null_req)
            r = ACT_NULL;
        else if (a.dev == id)
            r = ACT_LOCAL;
        else
            r = ACT_REMOTE;
        return r;
    endfunction

endpackage

// File: rtl/mq_port_decode.sv
module mq_port_decode
    import mq_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dev_id_t  strap_id,
    input  logic     en,
    input  logic     null_req,
    input  qaddr_t   addr,
    output qsel_t    sel,
    output sel_act_e act
);

    dev_id_t id_q;

    assign act = classify(en, null_req, addr, id_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q <= strap_id;
            sel  <= '0;
        end else begin
            unique case (act)
                ACT_LOCAL:  sel <= '{hit: 1'b1, que: addr.que};
                ACT_REMOTE,
                ACT_NULL:   sel.hit <= 1'b0;
                default:    sel <= sel;
            endcase
        end
    end

    // R4: no address cycle, selection holds
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sel));

    // R3: matching device field selects the addressed queue
    a_r3_hit_loads: assert property (@(posedge clk) disable iff (rst)
        (en && !null_req && addr.dev == id_q) |=> (sel.hit && sel.que == $past(addr.que)));

    // R3: foreign device field deselects and keeps the queue index
    a_r3_miss_keeps: assert property (@(posedge clk) disable iff (rst)
        (en && !null_req && addr.dev != id_q) |=> (!sel.hit && $stable(sel.que)));

    // R6: null request reads no queue
    a_r6_null_nohit: assert property (@(posedge clk) disable iff (rst)
        (en && null_req) |=> (!sel.hit && $stable(sel.que)));

endmodule

// File: rtl/mq_bus_owner.sv
module mq_bus_owner
    import mq_sel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strap_master,
    input  sel_act_e act,
    input  logic     oe_n,
    output logic     owner,
    output logic     dout_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            owner <= strap_master;
        end else begin
            unique case (act)
                ACT_LOCAL:  owner <= 1'b1;
                ACT_REMOTE: owner <= 1'b0;
                default:    owner <= owner;
            endcase
        end
    end

    // Output enable acts without a clock
    assign dout_en = owner & ~oe_n;

    // R7: own selection takes the bus
    a_r7_take: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOCAL) |=> owner);

    // R7: another device's selection releases the bus
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_REMOTE) |=> !owner);

    // R6: null selection leaves ownership alone
    a_r6_keep_owner: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_NULL || act == ACT_IDLE) |=> $stable(owner));

endmodule

// File: rtl/mq_dev_select.sv
module mq_dev_select
    import mq_sel_pkg::*;
(
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic [DEV_W-1:0]  strap_id,
    input  logic              strap_master,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              rd_en,
    input  logic              rd_null,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              oe_n,
    output logic              wr_hit,
    output logic [QUE_W-1:0]  wr_queue,
    output logic              rd_hit,
    output logic [QUE_W-1:0]  rd_queue,
    output logic              bus_owner,
    output logic              dout_en
);

    qsel_t    wsel, rsel;
    sel_act_e wact, ract;
    qaddr_t   waddr_s, raddr_s;

    assign waddr_s = qaddr_t'(wr_addr);
    assign raddr_s = qaddr_t'(rd_addr);

    mq_port_decode u_wdec (
        .clk      (wclk),
        .rst      (mrst),
        .strap_id (strap_id),
        .en       (wr_en),
        .null_req (1'b0),
        .addr     (waddr_s),
        .sel      (wsel),
        .act      (wact)
    );

    mq_port_decode u_rdec (
        .clk      (rclk),
        .rst      (mrst),
        .strap_id (strap_id),
        .en       (rd_en),
        .null_req (rd_null),
        .addr     (raddr_s),
        .sel      (rsel),
        .act      (ract)
    );

    mq_bus_owner u_own (
        .clk          (rclk),
        .rst          (mrst),
        .strap_master (strap_master),
        .act          (ract),
        .oe_n         (oe_n),
        .owner        (bus_owner),
        .dout_en      (dout_en)
    );

    assign wr_hit   = wsel.hit;
    assign wr_queue = wsel.que;
    assign rd_hit   = rsel.hit;
    assign rd_queue = rsel.que;

    // R7: a device reading a real queue must own the output bus
    a_r7_hit_owns: assert property (@(posedge rclk) disable iff (mrst)
        rd_hit |-> bus_owner);

    // R8: a disabled output enable never lets the device drive
    a_r8_oe_blocks: assert property (@(posedge rclk) disable iff (mrst)
        oe_n |-> !dout_en);

endmodule

// File: tb/mq_dev_select_tb_top.sv
module mq_dev_select_tb_top;

    localparam int NDEV = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       mrst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, rd_null = 1'b0, oe_n = 1'b0;
    logic [5:0] wr_addr = '0, rd_addr = '0;
    logic [2:0] sid   [NDEV];
    logic       smast [NDEV];

    logic       o_wh [NDEV];
    logic [2:0] o_wq [NDEV];
    logic       o_rh [NDEV];
    logic [2:0] o_rq [NDEV];
    logic       o_own[NDEV];
    logic       o_de [NDEV];

    for (genvar k = 0; k < NDEV; k++) begin : g_dev
        mq_dev_select dut_i (
            .wclk(clk), .rclk(clk), .mrst(mrst),
            .strap_id(sid[k]), .strap_master(smast[k]),
            .wr_en(wr_en), .wr_addr(wr_addr),
            .rd_en(rd_en), .rd_null(rd_null), .rd_addr(rd_addr),
            .oe_n(oe_n),
            .wr_hit(o_wh[k]), .wr_queue(o_wq[k]),
            .rd_hit(o_rh[k]), .rd_queue(o_rq[k]),
            .bus_owner(o_own[k]), .dout_en(o_de[k])
        );
    end

    // Behavioural reference, one entry per device
    int m_id[NDEV], m_own[NDEV], m_wh[NDEV], m_wq[NDEV], m_rh[NDEV], m_rq[NDEV];

    always @(posedge clk) begin
        for (int k = 0; k < NDEV; k++) begin
            if (mrst) begin
                m_id[k] = sid[k]; m_own[k] = smast[k];
                m_wh[k] = 0; m_wq[k] = 0; m_rh[k] = 0; m_rq[k] = 0;
            end else begin
                if (wr_en) begin
                    if (wr_addr / 8 == m_id[k]) begin m_wh[k] = 1; m_wq[k] = wr_addr % 8; end
                    else m_wh[k] = 0;
                end
                if (rd_en && rd_null) m_rh[k] = 0;
                else if (rd_en) begin
                    if (rd_addr / 8 == m_id[k]) begin
                        m_rh[k] = 1; m_rq[k] = rd_addr % 8; m_own[k] = 1;
                    end else begin
                        m_rh[k] = 0; m_own[k] = 0;
                    end
                end
            end
        end
    end

    int n_vec = 0, n_fail = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int drivers = 0;
        for (int k = 0; k < NDEV; k++) begin
            chk($sformatf("R3 wr_hit dev%0d", k), o_wh[k], m_wh[k]);
            chk($sformatf("R3 wr_queue dev%0d", k), o_wq[k], m_wq[k]);
            chk($sformatf("R5 rd_hit dev%0d", k), o_rh[k], m_rh[k]);
            chk($sformatf("R5 rd_queue dev%0d", k), o_rq[k], m_rq[k]);
            chk($sformatf("R7 bus_owner dev%0d", k), o_own[k], m_own[k]);
            chk($sformatf("R8 dout_en dev%0d", k), o_de[k], (m_own[k] != 0 && !oe_n) ? 1 : 0);
            drivers += int'(o_de[k]);
        end
        chk("R10 at most one driver", (drivers <= 1) ? 1 : 0, 1);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        mrst = 1'b1; wr_en = 0; rd_en = 0; rd_null = 0;
        step(); step();
        mrst = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        sid[0] = 3'd0; sid[1] = 3'd3; sid[2] = 3'd5; sid[3] = 3'd7;
        smast[0] = 0; smast[1] = 1; smast[2] = 0; smast[3] = 0;
        oe_n = 1'b0;
        do_reset();
        for (int k = 0; k < NDEV; k++) begin
            chk("R1 wr_hit cleared", o_wh[k], 0);
            chk("R1 rd_hit cleared", o_rh[k], 0);
            chk("R1 owner is master strap", o_own[k], smast[k]);
            if (!smast[k]) chk("R9 slave silent after reset", o_de[k], 0);
        end
        step();
        for (int k = 0; k < NDEV; k++)
            if (!smast[k]) chk("R9 slave silent with oe_n low", o_de[k], 0);

        // Write select of device ID 5, queue 6
        wr_en = 1; wr_addr = {3'd5, 3'd6}; step();
        chk("R3 write hit", o_wh[2], 1); chk("R3 write queue", o_wq[2], 6);
        chk("R3 others miss", o_wh[0], 0);
        // No address cycle: selection holds
        wr_en = 0; wr_addr = {3'd0, 3'd1}; step();
        chk("R4 hold hit", o_wh[2], 1); chk("R4 hold queue", o_wq[2], 6);
        chk("R4 idle no new hit", o_wh[0], 0);

        // Read select of device ID 7, queue 2: ownership moves
        rd_en = 1; rd_addr = {3'd7, 3'd2}; step();
        chk("R5 read hit", o_rh[3], 1); chk("R5 read queue", o_rq[3], 2);
        chk("R7 new owner", o_own[3], 1); chk("R7 master released", o_own[1], 0);
        chk("R9 slave drives once selected", o_de[3], 1);

        // Null queue request addressed elsewhere
        rd_null = 1; rd_addr = {3'd0, 3'd5}; step();
        chk("R6 null no hit", o_rh[3], 0); chk("R6 null keeps queue", o_rq[3], 2);
        chk("R6 null keeps owner", o_own[3], 1); chk("R6 null no owner change", o_own[0], 0);
        rd_null = 0; rd_en = 0;

        // Output enable acts between clock edges
        #1 oe_n = 1'b1; #1 chk("R8 async disable", o_de[3], 0);
        oe_n = 1'b0; #1 chk("R8 async enable", o_de[3], 1);

        // Mixed traffic
        for (int i = 0; i < 80; i++) begin
            wr_addr = 6'((i * 29 + 11) % 64);
            rd_addr = 6'((i * 23 + 3) % 64);
            wr_en   = (i % 4 != 1);
            rd_en   = (i % 3 != 2);
            rd_null = (i % 7 == 5);
            oe_n    = (i % 5 == 3);
            step();
        end
        rd_en = 0; wr_en = 0; rd_null = 0; oe_n = 0;

        // Strap change outside reset is ignored
        sid[2] = 3'd1;
        rd_en = 1; rd_addr = {3'd5, 3'd0}; step();
        chk("R2 old id still matches", o_rh[2], 1);
        rd_addr = {3'd1, 3'd4}; step();
        chk("R2 new id ignored", o_rh[2], 0);

        // New reset: master role moves to ID 0, ID of dev2 becomes 1
        smast[1] = 0; smast[0] = 1;
        do_reset();
        chk("R1 new master owns", o_own[0], 1);
        chk("R1 old master released", o_own[1], 0);
        chk("R9 previous owner silent", o_de[3], 0);
        rd_en = 1; rd_addr = {3'd1, 3'd4}; step();
        chk("R2 new id taken at reset", o_rh[2], 1);
        chk("R2 new id queue", o_rq[2], 4);
        rd_en = 0; step();

        summary();
        $finish;
    end

endmodule